// File: doc/BRIEF.md
# Priority-Masked Normal Interrupt Resolver

This block decides whether the normal interrupt request goes to the processor and which source the processor is told about when it reads the vector word. It takes a 64-bit candidate mask, which is the set of sources that are pending, enabled and routed to the normal (non-fast) line. It keeps a 4-bit priority for every source and a 5-bit threshold. The request is raised only when a candidate's priority is strictly above the threshold. The one exception is a threshold of all ones, which turns filtering off so that any candidate raises the request.

Software programs the priorities and the threshold through a simple word-addressed write port. It reads them back, and reads the vector, through a read port. A vector read returns the winning source and its priority. The winner is found by a balanced comparison tree with no regard to the threshold. In the same cycle the block issues a one-cycle acknowledge that carries the winner's index, so that the pending store outside the block can clear that source. The pending store itself lies outside this block.

Top module: `irq_resolver`

## Requirements
- R1: After reset the request and acknowledge outputs are low, the threshold reads back as 0x1F and every priority word reads back as zero.
- R2: The priority of source n is the 4-bit field starting at bit 4*(n mod 8) of priority word n/8.
- R3: Priority word k is written and read at word offset 15-k. Offset 8 holds word 7 and offset 15 holds word 0.
- R4: The threshold sits at word offset 1 and keeps only the low 5 bits of a write. The other read bits are zero.
- R5: When the threshold is 0x1F, the request equals "any candidate bit set".
- R6: For any other threshold, the request is high only when some candidate has a priority strictly greater than the threshold. A priority equal to the threshold does not count.
- R7: A read of word offset 16 reports the candidate with the highest priority and ignores the threshold.
- R8: Among candidates of equal priority, the higher source number wins the vector.
- R9: A vector read returns the source number in bits 21:16 and the priority in bits 3:0, with every other bit zero. With no candidate it returns 0xFFFFFFFF.
- R10: A vector read that finds a winner raises the acknowledge for exactly one cycle, with the winner's index on the acknowledge source. A read that finds no winner raises no acknowledge.
- R11: A write to offset 16 changes no state. Reads of unmapped offsets (for example 2) return zero.
- R12: Read data and acknowledge appear on the clock edge that samples the read strobe. The request reflects the candidates, threshold and priorities present at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cand_i | input | 64 | Candidate sources (pending, enabled, normal class) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Write word offset |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 6 | Read word offset |
| rd_data_o | output | 32 | Registered read data |
| req_o | output | 1 | Normal interrupt request level |
| ack_valid_o | output | 1 | One-cycle clear pulse for the vector winner |
| ack_src_o | output | 6 | Index of the source to clear |

## Verification
The hardest case to reach from the ports is a tie at the top of the tree between far-apart sources. An example is source 15 against source 63, which lie in different subtrees. Only the root compare then decides the result, and a wrong tie rule anywhere shows up only in that arrangement. The stimulus programs a repeating priority pattern in which sources n, n+16, n+32 and n+48 share a priority. It then applies candidate sets that pair such sources, including a set of all 64 sources, together with thresholds at, just below and above the relevant priority. The same pattern also exposes a reversed word mapping, because word k and word 15-k always hold different nibble patterns.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
    localparam int NUM_SRC     = 64;
    localparam int PRI_W       = 4;
    localparam int SRC_W       = $clog2(NUM_SRC);
    localparam int DATA_W      = 32;
    localparam int PRI_PER_WD  = DATA_W / PRI_W;
    localparam int NUM_WORDS   = NUM_SRC / PRI_PER_WD;
    localparam int MASK_W      = PRI_W + 1;
    localparam int ADDR_W      = 6;
    localparam int VEC_SRC_LSB = 16;

    localparam logic [ADDR_W-1:0] OFS_MASK   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFS_PRI_LO = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] OFS_PRI_HI = ADDR_W'(8 + NUM_WORDS - 1);
    localparam logic [ADDR_W-1:0] OFS_VEC    = ADDR_W'(16);

    typedef struct packed {
        logic             vld;
        logic [PRI_W-1:0] pri;
        logic [SRC_W-1:0] src;
    } cand_t;

    // lo covers lower source numbers; hi wins ties
    function automatic cand_t pick(cand_t lo, cand_t hi);
        if (hi.vld && (!lo.vld || hi.pri >= lo.pri)) return hi;
        return lo;
    endfunction
endpackage

// File: rtl/irq_prio_tree.sv
module irq_prio_tree
    import irq_res_pkg::*;
(
    input  logic [NUM_SRC-1:0]       cand_i,
    input  logic [NUM_SRC*PRI_W-1:0] prio_i,
    output cand_t                    win_o
);
    localparam int LVLS = $clog2(NUM_SRC);

    for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
        localparam int W = NUM_SRC >> l;
        cand_t nodes [W];
        if (l == 0) begin : g_leaf
            for (genvar n = 0; n < W; n++) begin : g_n
                assign nodes[n] = '{vld: cand_i[n],
                                    pri: prio_i[n*PRI_W +: PRI_W],
                                    src: SRC_W'(n)};
            end
        end else begin : g_node
            for (genvar j = 0; j < W; j++) begin : g_j
                assign nodes[j] = pick(g_lvl[l-1].nodes[2*j], g_lvl[l-1].nodes[2*j+1]);
            end
        end
    end

    assign win_o = g_lvl[LVLS].nodes[0];
endmodule

// File: rtl/irq_thresh.sv
module irq_thresh
    import irq_res_pkg::*;
(
    input  logic [NUM_SRC-1:0]       cand_i,
    input  logic [NUM_SRC*PRI_W-1:0] prio_i,
    input  logic [MASK_W-1:0]        mask_i,
    output logic                     hit_o
);
    logic [NUM_SRC-1:0] above;

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        assign above[n] = cand_i[n] && (MASK_W'(prio_i[n*PRI_W +: PRI_W]) > mask_i);
    end

    always_comb begin
        if (mask_i == '1) hit_o = |cand_i;
        else              hit_o = |above;
    end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
    import irq_res_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       cand_i,
    input  logic              wr_en_i,
    input  logic [5:0]        wr_addr_i,
    input  logic [31:0]       wr_data_i,
    input  logic              rd_en_i,
    input  logic [5:0]        rd_addr_i,
    output logic [31:0]       rd_data_o,
    output logic              req_o,
    output logic              ack_valid_o,
    output logic [5:0]        ack_src_o
);
    typedef struct packed {
        logic [NUM_WORDS*DATA_W-1:0] prio;
        logic [MASK_W-1:0]           mask;
        logic [DATA_W-1:0]           rdata;
        logic                        req;
        logic                        ack_v;
        logic [SRC_W-1:0]            ack_src;
    } state_t;

    state_t st_d, st_q;
    cand_t  win;
    logic   thr_hit;

    irq_prio_tree u_tree (.cand_i(cand_i), .prio_i(st_q.prio), .win_o(win));
    irq_thresh    u_thr  (.cand_i(cand_i), .prio_i(st_q.prio), .mask_i(st_q.mask), .hit_o(thr_hit));

    always_comb begin
        st_d       = st_q;
        st_d.ack_v = 1'b0;
        st_d.req   = thr_hit;
        if (wr_en_i) begin
            if (wr_addr_i == OFS_MASK) st_d.mask = wr_data_i[MASK_W-1:0];
            for (int k = 0; k < NUM_WORDS; k++) begin
                if (wr_addr_i == OFS_PRI_HI - ADDR_W'(k))
                    st_d.prio[k*DATA_W +: DATA_W] = wr_data_i;
            end
        end
        if (rd_en_i) begin
            st_d.rdata = '0;
            if (rd_addr_i == OFS_MASK) st_d.rdata = DATA_W'(st_q.mask);
            for (int k = 0; k < NUM_WORDS; k++) begin
                if (rd_addr_i == OFS_PRI_HI - ADDR_W'(k))
                    st_d.rdata = st_q.prio[k*DATA_W +: DATA_W];
            end
            if (rd_addr_i == OFS_VEC) begin
                if (win.vld) begin
                    st_d.rdata   = (DATA_W'(win.src) << VEC_SRC_LSB) | DATA_W'(win.pri);
                    st_d.ack_v   = 1'b1;
                    st_d.ack_src = win.src;
                end else begin
                    st_d.rdata = '1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o   = st_q.rdata;
    assign req_o       = st_q.req;
    assign ack_valid_o = st_q.ack_v;
    assign ack_src_o   = st_q.ack_src;

    assert_mask_trim_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == OFS_MASK) |=> (st_q.mask == $past(wr_data_i[MASK_W-1:0])));

    assert_open_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask == '1) |=> (req_o == $past(|cand_i)));

    assert_empty_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_addr_i == OFS_VEC && cand_i == '0) |=> (rd_data_o == '1 && !ack_valid_o));

    assert_ack_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_addr_i == OFS_VEC && |cand_i) |=>
        (ack_valid_o && rd_data_o[VEC_SRC_LSB +: SRC_W] == ack_src_o));

    assert_ack_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_o |-> $past(rd_en_i && rd_addr_i == OFS_VEC && |cand_i));

    assert_vec_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == OFS_VEC) |=> ($stable(st_q.prio) && $stable(st_q.mask)));
endmodule

// File: tb/test_irq_resolver.sv
module test_irq_resolver;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [63:0] cand;
        logic [4:0]  mask;
        logic        req;
        logic [31:0] vec;
    } vec_t;

    // priority of source n is n mod 16 once programmed
    localparam vec_t TBL [10] = '{
        '{64'h0,                   5'd31, 1'b0, 32'hFFFF_FFFF},
        '{64'h20,                  5'd31, 1'b1, 32'h0005_0005},
        '{64'h20,                  5'd5,  1'b0, 32'h0005_0005},
        '{64'h20,                  5'd4,  1'b1, 32'h0005_0005},
        '{64'h0000_0000_0008_0008, 5'd0,  1'b1, 32'h0013_0003},
        '{64'h8000_0000_0000_8000, 5'd14, 1'b1, 32'h003F_000F},
        '{64'h1,                   5'd0,  1'b0, 32'h0000_0000},
        '{64'h0001_8000_0000_0000, 5'd15, 1'b0, 32'h002F_000F},
        '{64'hFFFF_FFFF_FFFF_FFFF, 5'd16, 1'b0, 32'h003F_000F},
        '{64'h0000_0002_0000_0006, 5'd1,  1'b1, 32'h0002_0002}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cand = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        req, ack_v;
    logic [5:0]  ack_src;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_resolver i_irq_resolver (
        .clk(clk), .rst_n(rst_n), .cand_i(cand),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .req_o(req), .ack_valid_o(ack_v), .ack_src_o(ack_src)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d,
                      output logic av, output logic [5:0] as, output logic av_next);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data; av = ack_v; as = ack_src;
        @(negedge clk);
        av_next = ack_v;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic av, avn;
        logic [5:0] as;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 req after reset", req, 0);
        check("R1 ack after reset", ack_v, 0);
        rd(6'd1, d, av, as, avn);
        check("R1 mask reset value", d, 32'h1F);
        rd(6'd12, d, av, as, avn);
        check("R1 priority word reset", d, 0);

        // R3: word k at offset 15-k; even words 0x76543210, odd 0xFEDCBA98
        for (int k = 0; k < 8; k++)
            wr(6'(15 - k), (k % 2 == 0) ? 32'h7654_3210 : 32'hFEDC_BA98);
        rd(6'd15, d, av, as, avn);
        check("R3 offset 15 holds word 0", d, 32'h7654_3210);
        rd(6'd8, d, av, as, avn);
        check("R3 offset 8 holds word 7", d, 32'hFEDC_BA98);

        // R2 R5 R6 R7 R8 R9 R10: table walk
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            cand = TBL[i].cand;
            wr(6'd1, 32'(TBL[i].mask));
            @(negedge clk);
            check($sformatf("R5/R6 req row %0d", i), req, TBL[i].req);
            rd(6'd16, d, av, as, avn);
            check($sformatf("R2/R7/R8/R9 vector row %0d", i), d, TBL[i].vec);
            check($sformatf("R10 ack row %0d", i), av, (TBL[i].vec != 32'hFFFF_FFFF));
            if (TBL[i].vec != 32'hFFFF_FFFF)
                check($sformatf("R10 ack source row %0d", i), as, TBL[i].vec[21:16]);
            check($sformatf("R10 ack one cycle row %0d", i), avn, 0);
        end

        // R4: threshold keeps low 5 bits
        wr(6'd1, 32'hFFFF_FFE3);
        rd(6'd1, d, av, as, avn);
        check("R4 mask trimmed", d, 32'h03);

        // R11: vector offset ignores writes, unmapped offset reads zero
        wr(6'd16, 32'h1234_5678);
        rd(6'd1, d, av, as, avn);
        check("R11 mask unchanged", d, 32'h03);
        rd(6'd15, d, av, as, avn);
        check("R11 word 0 unchanged", d, 32'h7654_3210);
        rd(6'd2, d, av, as, avn);
        check("R11 unmapped reads zero", d, 0);

        // R12: request latency of one edge with threshold fixed at 31
        wr(6'd1, 32'h1F);
        @(negedge clk);
        cand = '0;
        @(negedge clk);
        check("R12 req low before change", req, 0);
        cand = 64'h4000_0000_0000_0000;
        @(negedge clk);
        check("R12 req after one edge", req, 1);
        // R6: priority equal to threshold does not request
        wr(6'd1, 32'd14);
        @(negedge clk);
        check("R6 equal priority no req", req, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule